// File: doc/BRIEF.md
# Serial Program-Mode Entry Detector

This block sits on the target side of a two-wire serial programming port. It decides when the device switches into its program/verify mode and when it leaves it. It watches three inputs. The first is a digital flag, made elsewhere, which says that the elevated programming voltage is present on the reset pin. The other two are a serial clock and a serial data line. Both serial lines arrive asynchronously and are synchronised into the system clock domain before use.

Once the voltage flag appears, the block waits for a settling interval measured in system clocks. It then shifts in 32 data bits, most significant bit first, one bit on each rising edge of the synchronised serial clock. The 32-bit word is compared with the fixed key 0x4D434850. On an exact match, the block raises a program-mode flag and a request that all unused I/O go to high impedance. A wrong word locks the detector until the voltage flag is removed and applied again.

The mode ends only when the voltage flag is removed. A removal that comes too soon after the last serial clock edge is reported on a protocol-violation output.

Top module: `pvm_entry_detect`

## Requirements
- R1: After reset, `prog_mode_o`, `io_hiz_o` and `exit_viol_o` are all 0.
- R2: Rising serial clock edges that arrive before the enable has been held for `SETTLE_CYC` system clocks are ignored and do not count as key bits.
- R3: After settling, 32 bits are sampled on synchronised rising edges of `ser_clk_i`, most significant bit first. If they equal 0x4D434850, `prog_mode_o` and `io_hiz_o` both go to 1 and stay at 1 while the enable is held.
- R4: If the 32 received bits differ from the key, the mode is not entered. Further serial edges, including a correct key, are then ignored until the enable is removed and reapplied.
- R5: When `hv_en_i` goes low, `prog_mode_o` and `io_hiz_o` are 0 no later than the second rising system clock edge afterwards.
- R6: Removing the enable in the middle of a key discards all bits received so far. A later attempt needs a complete fresh 32-bit key.
- R7: While the mode is active, further serial clock edges and data have no effect on `prog_mode_o`, `io_hiz_o` or `exit_viol_o`.
- R8: `exit_viol_o` goes to 1 when the enable is removed while the mode is active and fewer than `EXIT_IDLE_CYC` system clocks have passed since the last detected serial clock rise. It stays at 0 on a removal made after that interval. Once set, it holds until the enable is applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_en_i | input | 1 | Programming-voltage-present flag, synchronous to `clk` |
| ser_clk_i | input | 1 | Serial programming clock, asynchronous |
| ser_dat_i | input | 1 | Serial programming data, asynchronous |
| prog_mode_o | output | 1 | Program/verify mode active |
| io_hiz_o | output | 1 | Request high impedance on unused I/O |
| exit_viol_o | output | 1 | Enable removed too soon after the last serial clock edge |

## Verification
The assertions assume that `hv_en_i` is already synchronous to the system clock. They also assume that the serial data line is stable on both sides of each serial clock rise, so that the two synchronised lines agree at the detected edge. The stimulus drives every input on the falling system clock edge. Each serial bit is held for four system clocks at each level, which is well beyond the synchroniser latency. Data changes only while the serial clock is low.

// File: rtl/pvm_pkg.sv
package pvm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SHIFT,
    ST_ACTIVE,
    ST_LOCKED
  } pvm_state_e;

  localparam logic [31:0] PVM_KEY_DEFAULT = 32'h4D43_4850;

endpackage

// File: rtl/pvm_sync.sv
module pvm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pvm_sat_cnt.sv
module pvm_sat_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);

endmodule

// File: rtl/pvm_key_shift.sv
module pvm_key_shift #(
  parameter int              KEY_W   = 32,
  parameter logic [KEY_W-1:0] KEY_VAL = 32'h4D43_4850
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic shift_i,
  input  logic din_i,
  output logic last_o,
  output logic match_o
);

  localparam int CW = $clog2(KEY_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(KEY_W - 1);

  logic [KEY_W-2:0] sh_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[KEY_W-3:0], din_i};
      cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o  = (cnt_q == LAST_IDX);
  assign match_o = ({sh_q, din_i} == KEY_VAL);

endmodule

// File: rtl/pvm_entry_detect.sv
module pvm_entry_detect
  import pvm_pkg::*;
#(
  parameter int          SETTLE_CYC    = 24,
  parameter int          EXIT_IDLE_CYC = 16,
  parameter int          SYNC_STAGES   = 2,
  parameter int          KEY_W         = 32,
  parameter logic [31:0] KEY_VAL       = PVM_KEY_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic hv_en_i,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  output logic prog_mode_o,
  output logic io_hiz_o,
  output logic exit_viol_o
);

  logic       en_q;
  logic [1:0] ser_s;
  logic       sclk_s, sdat_s, sclk_d;
  logic       rise;
  logic       settle_done, idle_done;
  logic       key_last, key_match, shift_en;
  logic       prog_q, hiz_q, viol_q;
  pvm_state_e st_q, st_n;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= hv_en_i;
  end

  pvm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_clk_i, ser_dat_i}),
    .q_o (ser_s)
  );

  assign sclk_s = ser_s[1];
  assign sdat_s = ser_s[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;

  pvm_sat_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (st_q != ST_SETTLE),
    .inc_i  (1'b1),
    .done_o (settle_done)
  );

  pvm_sat_cnt #(.LIMIT(EXIT_IDLE_CYC)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (rise || !en_q),
    .inc_i  (1'b1),
    .done_o (idle_done)
  );

  assign shift_en = en_q && (st_q == ST_SHIFT) && rise;

  pvm_key_shift #(.KEY_W(KEY_W), .KEY_VAL(KEY_VAL[KEY_W-1:0])) u_key (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (!en_q || st_q == ST_IDLE),
    .shift_i (shift_en),
    .din_i   (sdat_s),
    .last_o  (key_last),
    .match_o (key_match)
  );

  always_comb begin
    st_n = st_q;
    if (!en_q) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:   st_n = ST_SETTLE;
        ST_SETTLE: if (settle_done) st_n = ST_SHIFT;
        ST_SHIFT:  if (shift_en && key_last) st_n = key_match ? ST_ACTIVE : ST_LOCKED;
        default:   st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b0;
      hiz_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      prog_q <= (st_n == ST_ACTIVE);
      hiz_q  <= (st_n == ST_ACTIVE);
      if (st_q == ST_IDLE && en_q)
        viol_q <= 1'b0;
      else if (!en_q && st_q == ST_ACTIVE && !idle_done)
        viol_q <= 1'b1;
    end
  end

  assign prog_mode_o = prog_q;
  assign io_hiz_o    = hiz_q;
  assign exit_viol_o = viol_q;

endmodule

// File: rtl/pvm_entry_chk.sv
module pvm_entry_chk
  import pvm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en_q,
  input pvm_state_e st_q,
  input logic       shift_en,
  input logic       key_last,
  input logic       key_match,
  input logic       prog_mode_o,
  input logic       io_hiz_o,
  input logic       exit_viol_o
);

  assert_mode_drops_R5: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!prog_mode_o && !io_hiz_o));

  assert_entry_needs_key_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_mode_o) |-> $past(shift_en && key_last && key_match));

  assert_locked_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOCKED && en_q) |=> !prog_mode_o);

  assert_viol_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(exit_viol_o) |-> $past(st_q == ST_ACTIVE && !en_q));

  assert_mode_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    prog_mode_o |-> $past(en_q));

  assert_no_shift_early_R2: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> (st_q == ST_SHIFT));

endmodule

bind pvm_entry_detect pvm_entry_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_q        (en_q),
  .st_q        (st_q),
  .shift_en    (shift_en),
  .key_last    (key_last),
  .key_match   (key_match),
  .prog_mode_o (prog_mode_o),
  .io_hiz_o    (io_hiz_o),
  .exit_viol_o (exit_viol_o)
);

// File: tb/pvm_entry_detect_tb_top.sv
`timescale 1ns/1ps
module pvm_entry_detect_tb_top;

  localparam int SETTLE = 24;
  localparam int IDLE   = 16;
  localparam logic [31:0] GOOD_KEY = 32'h4D43_4850;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hv_en = 1'b0;
  logic sclk = 1'b0;
  logic sdat = 1'b0;
  logic prog, hiz, viol;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pvm_entry_detect #(.SETTLE_CYC(SETTLE), .EXIT_IDLE_CYC(IDLE)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .hv_en_i     (hv_en),
    .ser_clk_i   (sclk),
    .ser_dat_i   (sdat),
    .prog_mode_o (prog),
    .io_hiz_o    (hiz),
    .exit_viol_o (viol)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdat = b;
    cycles(4);
    sclk = 1'b1;
    cycles(4);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic en_on();
    @(negedge clk);
    hv_en = 1'b1;
    cycles(SETTLE + 10);
  endtask

  task automatic en_off();
    @(negedge clk);
    hv_en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clean_exit();
    cycles(IDLE + 12);
    en_off();
  endtask

  task automatic t_reset();
    chk("R1", "prog after reset", prog, 1'b0);
    chk("R1", "hiz after reset",  hiz,  1'b0);
    chk("R1", "viol after reset", viol, 1'b0);
  endtask

  task automatic t_entry();
    en_on();
    send_bits(GOOD_KEY, 32);
    cycles(8);
    chk("R3", "prog after key", prog, 1'b1);
    chk("R3", "hiz after key",  hiz,  1'b1);
    clean_exit();
    chk("R5", "prog two clocks after removal", prog, 1'b0);
    chk("R5", "hiz two clocks after removal",  hiz,  1'b0);
    chk("R8", "no viol on late removal", viol, 1'b0);
  endtask

  task automatic t_settle();
    @(negedge clk);
    hv_en = 1'b1;
    send_bits(32'h3, 2);
    cycles(SETTLE);
    send_bits(GOOD_KEY, 32);
    cycles(8);
    chk("R2", "early edges ignored, key accepted", prog, 1'b1);
    clean_exit();
  endtask

  task automatic t_mismatch();
    en_on();
    send_bits(GOOD_KEY ^ 32'h1, 32);
    cycles(8);
    chk("R4", "wrong key rejected", prog, 1'b0);
    send_bits(GOOD_KEY, 32);
    cycles(8);
    chk("R4", "locked ignores good key", prog, 1'b0);
    chk("R4", "locked hiz low", hiz, 1'b0);
    en_off();
    en_on();
    send_bits(GOOD_KEY, 32);
    cycles(8);
    chk("R4", "good key after reapply", prog, 1'b1);
    clean_exit();
  endtask

  task automatic t_partial();
    en_on();
    send_bits(GOOD_KEY >> 16, 16);
    en_off();
    chk("R6", "no mode after partial key", prog, 1'b0);
    en_on();
    send_bits(GOOD_KEY, 32);
    cycles(8);
    chk("R6", "fresh full key accepted", prog, 1'b1);
    clean_exit();
  endtask

  task automatic t_ignore();
    en_on();
    send_bits(GOOD_KEY, 32);
    cycles(8);
    send_bits(32'hA5, 8);
    cycles(6);
    chk("R7", "prog held during traffic", prog, 1'b1);
    chk("R7", "hiz held during traffic",  hiz,  1'b1);
    chk("R7", "viol untouched by traffic", viol, 1'b0);
    clean_exit();
  endtask

  task automatic t_viol();
    en_on();
    send_bits(GOOD_KEY, 32);
    en_off();
    chk("R8", "viol on early removal", viol, 1'b1);
    chk("R5", "prog low on early removal", prog, 1'b0);
    cycles(5);
    chk("R8", "viol held while removed", viol, 1'b1);
    en_on();
    chk("R8", "viol cleared on reapply", viol, 1'b0);
    en_off();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    cycles(4);
    rst = 1'b0;
    cycles(2);
    t_reset();
    t_entry();
    t_settle();
    t_mismatch();
    t_partial();
    t_ignore();
    t_viol();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule